// File: doc/BRIEF.md
# ECC Fault Status and Capture Monitor

This block gathers error reports from the ECC checkers of two memories, an SRAM and a flash. Each memory supplies two one-cycle strobes. One says that a single-bit error was corrected. The other says that an error could not be corrected. With the strobes come the faulting address, the bus attributes, the master identifier and the data word. Each of the four event kinds has its own sticky flag. A flag can only be set while its report-enable bit is on. Software clears a flag by writing a one to it.

A single interrupt request is raised while any flag is set and its enable bit is on. For each memory, one set of capture registers holds the details of the most recent event that was reported for that memory. When several enabled events arrive in one cycle, a fixed priority picks one of them. Only that event sets its flag and loads its capture registers. The others in that cycle are dropped.

Software reaches all of this through a simple synchronous port with a 3-bit word address. A write takes effect at the next rising clock edge. Read data is combinational from the registers.

Top module: `ecc_fault_monitor`

## Requirements
- R1: After reset the control word, the status word, the interrupt request and all six capture words read as zero.
- R2: The status word is at address 1. Its bit 5 is SRAM corrected, bit 4 is flash corrected, bit 1 is SRAM uncorrectable and bit 0 is flash uncorrectable. All other bits read 0.
- R3: A flag is set by its event strobe only while its enable bit in the control word (address 0, same bit positions as the status word) is 1.
- R4: Writing 1 to a status bit clears that flag. Writing 0 to a status bit leaves it unchanged.
- R5: The interrupt request is the OR over the four flags of each flag ANDed with its enable. It falls in the cycle after the last active flag is cleared or its enable is removed.
- R6: If a flag's event and a write-one-clear of the same flag occur in the same cycle, the flag ends up set.
- R7: Among the enabled events of one cycle, only the highest-priority one is recorded. The order, highest first, is SRAM corrected, flash corrected, SRAM uncorrectable, flash uncorrectable.
- R8: A recorded SRAM event loads the SRAM capture words, and a recorded flash event loads the flash capture words. The address is at address 2 (SRAM) or 5 (flash). The master ID in bits [11:8] and the attributes in bits [7:0] are at 3 or 6. The data is at 4 or 7.
- R9: A memory's capture words keep their value unless an event for that memory is recorded. Disabled events and events that lose the priority do not load them.
- R10: Only bits 5, 4, 1 and 0 of the control word are writable. The rest read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sram_cor_i | input | 1 | SRAM single-bit corrected strobe |
| sram_unc_i | input | 1 | SRAM uncorrectable strobe |
| sram_addr_i | input | ADDR_W | SRAM faulting address |
| sram_attr_i | input | ATTR_W | SRAM access attributes |
| sram_mid_i | input | MID_W | SRAM requesting master ID |
| sram_data_i | input | DATA_W | SRAM faulting data |
| flash_cor_i | input | 1 | Flash single-bit corrected strobe |
| flash_unc_i | input | 1 | Flash uncorrectable strobe |
| flash_addr_i | input | ADDR_W | Flash faulting address |
| flash_attr_i | input | ATTR_W | Flash access attributes |
| flash_mid_i | input | MID_W | Flash requesting master ID |
| flash_data_i | input | DATA_W | Flash faulting data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 8 | Write data (control and status) |
| reg_rdata_o | output | REG_W | Read data for reg_addr_i |
| irq_o | output | 1 | Combined ECC interrupt request |

## Verification
Two things can land on the same edge. A status flag can be set by an event and cleared by software at once, and several memory events can arrive together. The bench drives a write-one-clear of the SRAM corrected flag in the cycle where that event also strobes, and it expects the flag to stay set. It also drives mixes of simultaneous strobes under different enable masks. For each mix it judges which single flag appears and which memory's capture words change, while the other memory's words must keep their earlier values.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
    localparam int NUM_EV = 4;

    // internal event index; higher index = higher priority
    typedef enum logic [1:0] {
        EV_FLASH_UNC = 2'd0,
        EV_SRAM_UNC  = 2'd1,
        EV_FLASH_COR = 2'd2,
        EV_SRAM_COR  = 2'd3
    } ev_idx_e;

    localparam logic [2:0] RA_CTRL       = 3'd0;
    localparam logic [2:0] RA_STAT       = 3'd1;
    localparam logic [2:0] RA_SRAM_ADDR  = 3'd2;
    localparam logic [2:0] RA_SRAM_INFO  = 3'd3;
    localparam logic [2:0] RA_SRAM_DATA  = 3'd4;
    localparam logic [2:0] RA_FLASH_ADDR = 3'd5;
    localparam logic [2:0] RA_FLASH_INFO = 3'd6;
    localparam logic [2:0] RA_FLASH_DATA = 3'd7;

    // map the 4-bit internal vector onto the 8-bit software view
    function automatic logic [7:0] to_byte(input logic [3:0] v);
        return {2'b00, v[3], v[2], 2'b00, v[1], v[0]};
    endfunction

    function automatic logic [3:0] from_byte(input logic [7:0] b);
        return {b[5], b[4], b[1], b[0]};
    endfunction
endpackage

// File: rtl/ecc_flag_unit.sv
module ecc_flag_unit
    import ecc_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              ctrl_wr_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        wbyte_i,
    output logic [NUM_EV-1:0] en_o,
    output logic [NUM_EV-1:0] flags_o,
    output logic [NUM_EV-1:0] grant_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_EV-1:0] en;
        logic [NUM_EV-1:0] flags;
    } flag_state_t;

    flag_state_t s_d, s_q;
    logic [NUM_EV-1:0] req;
    logic [NUM_EV-1:0] grant;
    logic              taken;

    always_comb begin
        req   = ev_i & s_q.en;
        grant = '0;
        taken = 1'b0;
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end

        s_d = s_q;
        if (ctrl_wr_i) s_d.en = from_byte(wbyte_i);
        if (stat_wr_i) s_d.flags = s_d.flags & ~from_byte(wbyte_i);
        s_d.flags = s_d.flags | grant;   // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o    = s_q.en;
    assign flags_o = s_q.flags;
    assign grant_o = grant;
    assign irq_o   = |(s_q.flags & s_q.en);

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R7

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_o[g]) |-> $past(en_o[g])); // R3
        AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[g] |=> flags_o[g]); // R6
    end
endmodule

// File: rtl/ecc_fault_latch.sv
module ecc_fault_latch #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 8,
    parameter int MID_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic [MID_W-1:0]  mid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic [MID_W-1:0]  mid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
        logic [MID_W-1:0]  mid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (cap_i) begin
            c_d.addr = addr_i;
            c_d.attr = attr_i;
            c_d.mid  = mid_i;
            c_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign addr_o = c_q.addr;
    assign attr_o = c_q.attr;
    assign mid_o  = c_q.mid;
    assign data_o = c_q.data;

    AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(addr_o) && $stable(attr_o) && $stable(mid_o) && $stable(data_o))); // R9
    AST_CAPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (addr_o == $past(addr_i) && data_o == $past(data_i))); // R8
endmodule

// File: rtl/ecc_fault_monitor.sv
module ecc_fault_monitor
    import ecc_mon_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 8,
    parameter int MID_W  = 4,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sram_cor_i,
    input  logic              sram_unc_i,
    input  logic [ADDR_W-1:0] sram_addr_i,
    input  logic [ATTR_W-1:0] sram_attr_i,
    input  logic [MID_W-1:0]  sram_mid_i,
    input  logic [DATA_W-1:0] sram_data_i,
    input  logic              flash_cor_i,
    input  logic              flash_unc_i,
    input  logic [ADDR_W-1:0] flash_addr_i,
    input  logic [ATTR_W-1:0] flash_attr_i,
    input  logic [MID_W-1:0]  flash_mid_i,
    input  logic [DATA_W-1:0] flash_data_i,
    input  logic              reg_wr_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    localparam int NUM_MEM = 2;   // 0 = SRAM, 1 = flash
    localparam int INFO_W  = MID_W + ATTR_W;

    logic [NUM_EV-1:0] ev, en, flags, grant;
    logic [NUM_MEM-1:0] cap;
    logic [ADDR_W-1:0] in_addr [NUM_MEM];
    logic [ATTR_W-1:0] in_attr [NUM_MEM];
    logic [MID_W-1:0]  in_mid  [NUM_MEM];
    logic [DATA_W-1:0] in_data [NUM_MEM];
    logic [ADDR_W-1:0] q_addr  [NUM_MEM];
    logic [ATTR_W-1:0] q_attr  [NUM_MEM];
    logic [MID_W-1:0]  q_mid   [NUM_MEM];
    logic [DATA_W-1:0] q_data  [NUM_MEM];

    always_comb begin
        ev = '0;
        ev[EV_SRAM_COR]  = sram_cor_i;
        ev[EV_FLASH_COR] = flash_cor_i;
        ev[EV_SRAM_UNC]  = sram_unc_i;
        ev[EV_FLASH_UNC] = flash_unc_i;
    end

    ecc_flag_unit u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .ctrl_wr_i (reg_wr_i && reg_addr_i == RA_CTRL),
        .stat_wr_i (reg_wr_i && reg_addr_i == RA_STAT),
        .wbyte_i   (reg_wdata_i),
        .en_o      (en),
        .flags_o   (flags),
        .grant_o   (grant),
        .irq_o     (irq_o)
    );

    assign cap[0] = grant[EV_SRAM_COR]  | grant[EV_SRAM_UNC];
    assign cap[1] = grant[EV_FLASH_COR] | grant[EV_FLASH_UNC];

    assign in_addr[0] = sram_addr_i;   assign in_addr[1] = flash_addr_i;
    assign in_attr[0] = sram_attr_i;   assign in_attr[1] = flash_attr_i;
    assign in_mid[0]  = sram_mid_i;    assign in_mid[1]  = flash_mid_i;
    assign in_data[0] = sram_data_i;   assign in_data[1] = flash_data_i;

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
        ecc_fault_latch #(
            .ADDR_W (ADDR_W), .ATTR_W (ATTR_W), .MID_W (MID_W), .DATA_W (DATA_W)
        ) u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_i  (cap[m]),
            .addr_i (in_addr[m]),
            .attr_i (in_attr[m]),
            .mid_i  (in_mid[m]),
            .data_i (in_data[m]),
            .addr_o (q_addr[m]),
            .attr_o (q_attr[m]),
            .mid_o  (q_mid[m]),
            .data_o (q_data[m])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            RA_CTRL:       reg_rdata_o = REG_W'(to_byte(en));
            RA_STAT:       reg_rdata_o = REG_W'(to_byte(flags));
            RA_SRAM_ADDR:  reg_rdata_o = REG_W'(q_addr[0]);
            RA_SRAM_INFO:  reg_rdata_o = REG_W'(INFO_W'({q_mid[0], q_attr[0]}));
            RA_SRAM_DATA:  reg_rdata_o = REG_W'(q_data[0]);
            RA_FLASH_ADDR: reg_rdata_o = REG_W'(q_addr[1]);
            RA_FLASH_INFO: reg_rdata_o = REG_W'(INFO_W'({q_mid[1], q_attr[1]}));
            default:       reg_rdata_o = REG_W'(q_data[1]);
        endcase
    end

    AST_ONE_MEM_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap[0] && cap[1])); // R7
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == RA_CTRL && reg_wdata_i == 8'h00) |=> !irq_o); // R5
endmodule

// File: tb/sim_ecc_fault_monitor.sv
module sim_ecc_fault_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sram_cor = 0, sram_unc = 0, flash_cor = 0, flash_unc = 0;
    logic [31:0] sram_addr = 0, sram_data = 0, flash_addr = 0, flash_data = 0;
    logic [7:0]  sram_attr = 0, flash_attr = 0;
    logic [3:0]  sram_mid = 0, flash_mid = 0;
    logic        wr = 0;
    logic [2:0]  ra = 0;
    logic [7:0]  wd = 0;
    logic [31:0] rd;
    logic        irq;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    ecc_fault_monitor u0 (
        .clk(clk), .rst_n(rst_n),
        .sram_cor_i(sram_cor), .sram_unc_i(sram_unc), .sram_addr_i(sram_addr),
        .sram_attr_i(sram_attr), .sram_mid_i(sram_mid), .sram_data_i(sram_data),
        .flash_cor_i(flash_cor), .flash_unc_i(flash_unc), .flash_addr_i(flash_addr),
        .flash_attr_i(flash_attr), .flash_mid_i(flash_mid), .flash_data_i(flash_data),
        .reg_wr_i(wr), .reg_addr_i(ra), .reg_wdata_i(wd),
        .reg_rdata_o(rd), .irq_o(irq)
    );

    // nibble order {sram_cor, flash_cor, sram_unc, flash_unc}; byte bits 5,4,1,0
    function automatic logic [7:0] nb2byte(input logic [3:0] n);
        return {2'b00, n[3], n[2], 2'b00, n[1], n[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        wr = 1; ra = a; wd = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] v);
        ra = a; #1; v = rd;
    endtask

    task automatic pulse(input logic [3:0] n);
        {sram_cor, flash_cor, sram_unc, flash_unc} = n;
        @(negedge clk);
        {sram_cor, flash_cor, sram_unc, flash_unc} = 4'b0;
    endtask

    // {enable nibble, event nibble, expected flag nibble}
    localparam logic [11:0] VEC [9] = '{
        12'hF_8_8, 12'hF_F_8, 12'hF_7_4, 12'hF_3_2, 12'hF_1_1,
        12'h7_C_4, 12'h0_F_0, 12'hA_5_0, 12'hA_7_2
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rreg(3'(a), v); check("R1 reset reg", v, 0);
        end
        check("R1 reset irq", {31'b0, irq}, 0);
        rst_n = 1;
        @(negedge clk);

        // R10 control writable bits only
        wreg(3'd0, 8'hFF); rreg(3'd0, v); check("R10 ctrl mask", v, 32'h33);

        // table walk: R2 R3 R7
        for (int i = 0; i < 9; i++) begin
            wreg(3'd0, nb2byte(VEC[i][11:8]));
            wreg(3'd1, 8'hFF);
            pulse(VEC[i][7:4]);
            rreg(3'd1, v); check("R7/R3/R2 status vector", v, {24'b0, nb2byte(VEC[i][3:0])});
            check("R5 irq vector", {31'b0, irq}, {31'b0, |VEC[i][3:0]});
        end

        // R4 W1C, write 0 no effect, R5 irq drop
        wreg(3'd0, 8'h33); wreg(3'd1, 8'hFF);
        pulse(4'b1000); pulse(4'b0001);
        rreg(3'd1, v); check("R2 two flags", v, 32'h21);
        wreg(3'd1, 8'h00); rreg(3'd1, v); check("R4 write zero", v, 32'h21);
        wreg(3'd1, 8'h01); rreg(3'd1, v); check("R4 clear one", v, 32'h20);
        check("R5 irq still up", {31'b0, irq}, 1);
        wreg(3'd1, 8'h20); check("R5 irq drop", {31'b0, irq}, 0);
        // R5 irq drops when enable removed
        pulse(4'b0010); check("R5 irq set", {31'b0, irq}, 1);
        wreg(3'd0, 8'h00); check("R5 irq gated", {31'b0, irq}, 0);
        rreg(3'd1, v); check("R5 flag sticky", v, 32'h02);

        // R6 set beats clear in same cycle
        wreg(3'd0, 8'h33); wreg(3'd1, 8'hFF);
        pulse(4'b1000);
        wr = 1; ra = 3'd1; wd = 8'h20; sram_cor = 1;
        @(negedge clk);
        wr = 0; sram_cor = 0;
        rreg(3'd1, v); check("R6 set wins", v, 32'h20);

        // R8 SRAM capture
        sram_addr = 32'h1000_00A4; sram_data = 32'hDEAD_BEEF; sram_attr = 8'h5A; sram_mid = 4'h3;
        pulse(4'b0010);
        rreg(3'd2, v); check("R8 sram addr", v, 32'h1000_00A4);
        rreg(3'd3, v); check("R8 sram info", v, 32'h0000_035A);
        rreg(3'd4, v); check("R8 sram data", v, 32'hDEAD_BEEF);
        rreg(3'd5, v); check("R9 flash untouched", v, 0);

        // R9 disabled flash event not captured
        wreg(3'd0, 8'h22);
        flash_addr = 32'h0040_0010; flash_data = 32'h1234_5678; flash_attr = 8'hC1; flash_mid = 4'h7;
        pulse(4'b0101);
        rreg(3'd5, v); check("R9 disabled flash", v, 0);
        // R8 flash capture
        wreg(3'd0, 8'h33);
        pulse(4'b0001);
        rreg(3'd5, v); check("R8 flash addr", v, 32'h0040_0010);
        rreg(3'd6, v); check("R8 flash info", v, 32'h0000_07C1);
        rreg(3'd7, v); check("R8 flash data", v, 32'h1234_5678);

        // R7/R9 priority decides capture: flash_cor beats sram_unc
        sram_addr = 32'hAAAA_0000; flash_addr = 32'hBBBB_0000;
        wreg(3'd1, 8'hFF);
        pulse(4'b0110);
        rreg(3'd1, v); check("R7 flash cor wins", v, 32'h10);
        rreg(3'd2, v); check("R9 sram held on loss", v, 32'h1000_00A4);
        rreg(3'd5, v); check("R8 flash winner captured", v, 32'hBBBB_0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule